// File: doc/BRIEF.md
# Six-Lane MAC Client to AXI4-Stream Adapter

This block sits next to a 100G Ethernet MAC whose client port is split into six 64-bit lanes, each with its own small control word. On receive it gathers the six lanes of one MAC cycle into a single 384-bit AXI4-Stream beat. It works out the byte-enable mask from the lane flags and marks the final beat of each frame with TLAST. On transmit it spreads each accepted 384-bit stream beat back over the six lanes and rebuilds their control words, including the start marker, the end marker and the count of unused bytes.

The client port is non-segmented, so no beat ever carries the tail of one frame together with the head of the next. The whole adapter runs on the MAC client clock. The receive stream has no TREADY: the MAC cannot be paused, so the consumer must take a beat in every cycle that m_tvalid is high. On transmit, s_tready is the MAC's ready passed straight through. A stream beat is taken on each clock edge where s_tvalid and s_tready are both high. The MAC takes the lane word shown on tx_lane_data and tx_lane_ctrl on each edge where tx_mac_ready is high. While that ready is low, the lane word holds.

Top module: `lane_stream_adapter`

## Requirements
- R1: Lane k occupies data bits [64k+63:64k], with byte j of the lane at bits [64k+8j+7:64k+8j], and its control word occupies control bits [7k+6:7k] on both paths. In a control word, bit 0 marks the lane valid, bit 1 marks start of frame, bit 2 marks end of frame, bit 3 marks a frame error, and bits 6:4 give the number of unused upper bytes in the end lane.
- R2: One cycle after an edge that samples rx lane 0 valid, m_tvalid is high and m_tdata equals the sampled lane data. After an edge that samples lane 0 invalid, m_tvalid is low.
- R3: In a receive beat with an end lane E, m_tkeep is all ones for lanes below E, has the low (8 - empty) bits set for lane E, and is zero for lanes above E. In a beat without an end lane, each lane's eight bits equal its valid flag.
- R4: m_tlast is high exactly when a valid lane of the beat carries the end flag. m_tuser is the error flag of that end lane and is zero on beats that are not last.
- R5: While rst_n is low, m_tvalid is low and every tx lane control word is zero.
- R6: s_tready equals tx_mac_ready in every cycle.
- R7: After an edge with tx_mac_ready high, tx_lane_data holds the beat accepted at that edge, and lane k is flagged valid exactly when any of its eight s_tkeep bits is set. If no beat was accepted at that edge, all lane control words are zero.
- R8: Lane 0 start-of-frame is set on the first beat of each transmit frame (the first beat after reset or after a beat with s_tlast) and on no other beat or lane.
- R9: On a transmit beat with s_tlast, only the highest lane with a set keep bit carries the end flag. Its empty field is (8 - kept bytes) mod 8 and its error flag equals s_tuser. On every other lane and beat the end, error and empty fields are zero.
- R10: After an edge with tx_mac_ready low, tx_lane_data and tx_lane_ctrl are unchanged. Every accepted beat therefore reaches the lanes exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | MAC client clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_lane_data | input | 384 | Receive data of six lanes from MAC |
| rx_lane_ctrl | input | 42 | Receive control words, 7 bits per lane |
| m_tvalid | output | 1 | Receive stream beat valid |
| m_tdata | output | 384 | Receive stream data |
| m_tkeep | output | 48 | Receive stream byte enables |
| m_tlast | output | 1 | Final beat of a frame |
| m_tuser | output | 1 | Frame error on the final beat |
| tx_lane_data | output | 384 | Transmit data of six lanes to MAC |
| tx_lane_ctrl | output | 42 | Transmit control words, 7 bits per lane |
| tx_mac_ready | input | 1 | MAC takes the presented lane word |
| s_tvalid | input | 1 | Transmit stream beat valid |
| s_tready | output | 1 | Transmit stream ready |
| s_tdata | input | 384 | Transmit stream data |
| s_tkeep | input | 48 | Transmit stream byte enables, contiguous from bit 0 |
| s_tlast | input | 1 | Final beat of a transmit frame |
| s_tuser | input | 1 | Mark the transmit frame as errored |

## Verification
The assertions watch several properties on every cycle: the one-cycle receive handshake, the absence of error marking on beats that are not last, a set first keep bit on every receive beat, and the lane word holding still while the MAC stalls. On the transmit lanes they also require at most one end flag per word, error flags only beside an end flag, and start flags only on valid lanes. The exact keep masks, the empty counts derived from frame length, the placement of the start flag over frame boundaries, and the lossless order of beats under random stalls depend on whole frames. Only the bench's frame scenarios can show those, including one-byte frames, frames that end exactly on a lane or beat edge, and frames one byte past a beat.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int LANE_W = 64;
  localparam int LANE_B = LANE_W / 8;
  localparam int EMP_W  = $clog2(LANE_B);

  // control word, LSB first: valid, sop, eop, err, empty
  typedef struct packed {
    logic [EMP_W-1:0] empty;
    logic             err;
    logic             eop;
    logic             sop;
    logic             vld;
  } lane_ctrl_t;

  localparam int CTRL_W = $bits(lane_ctrl_t);
  localparam int B_VLD  = 0;
  localparam int B_SOP  = 1;
  localparam int B_EOP  = 2;
  localparam int B_ERR  = 3;
endpackage

// File: rtl/lsa_rx_pack.sv
module lsa_rx_pack
  import lsa_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES*LANE_W-1:0]  lane_data,
  input  logic [LANES*CTRL_W-1:0]  lane_ctrl,
  output logic                     tvalid,
  output logic [LANES*LANE_W-1:0]  tdata,
  output logic [LANES*LANE_B-1:0]  tkeep,
  output logic                     tlast,
  output logic                     tuser
);
  localparam int IDX_W = $clog2(LANES);

  lane_ctrl_t                ctl [LANES];
  logic                      found;
  logic [IDX_W-1:0]          eidx;
  logic [LANES*LANE_B-1:0]   keep_n;
  logic                      user_n;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign ctl[g] = lane_ctrl_t'(lane_ctrl[g*CTRL_W +: CTRL_W]);
  end

  // lowest valid lane carrying the end flag
  always_comb begin
    found = 1'b0;
    eidx  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && ctl[i].vld && ctl[i].eop) begin
        found = 1'b1;
        eidx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    user_n = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (found) begin
        if (IDX_W'(i) < eidx)
          keep_n[i*LANE_B +: LANE_B] = '1;
        else if (IDX_W'(i) == eidx) begin
          keep_n[i*LANE_B +: LANE_B] = {LANE_B{1'b1}} >> ctl[i].empty;
          user_n = ctl[i].err;
        end else
          keep_n[i*LANE_B +: LANE_B] = '0;
      end else begin
        keep_n[i*LANE_B +: LANE_B] = {LANE_B{ctl[i].vld}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvalid <= 1'b0;
      tdata  <= '0;
      tkeep  <= '0;
      tlast  <= 1'b0;
      tuser  <= 1'b0;
    end else begin
      tvalid <= ctl[0].vld;
      tdata  <= lane_data;
      tkeep  <= keep_n;
      tlast  <= found;
      tuser  <= user_n;
    end
  end
endmodule

// File: rtl/lsa_tx_unpack.sv
module lsa_tx_unpack
  import lsa_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_tvalid,
  output logic                     s_tready,
  input  logic [LANES*LANE_W-1:0]  s_tdata,
  input  logic [LANES*LANE_B-1:0]  s_tkeep,
  input  logic                     s_tlast,
  input  logic                     s_tuser,
  input  logic                     mac_ready,
  output logic [LANES*LANE_W-1:0]  lane_data,
  output logic [LANES*CTRL_W-1:0]  lane_ctrl
);
  localparam int IDX_W = $clog2(LANES);

  logic [LANES-1:0]         lane_used;
  logic [IDX_W-1:0]         lidx;
  logic [EMP_W-1:0]         emp;
  logic                     in_frame;
  logic [LANES*CTRL_W-1:0]  ctrl_n;
  logic                     take;

  assign s_tready = mac_ready;
  assign take     = s_tvalid && mac_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_used
    assign lane_used[g] = |s_tkeep[g*LANE_B +: LANE_B];
  end

  // highest lane holding bytes and its unused byte count
  always_comb begin
    lidx = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_used[i]) lidx = IDX_W'(i);
    emp = EMP_W'(LANE_B - $countones(s_tkeep[lidx*LANE_B +: LANE_B]));
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_ctrl_t c;
      c       = '0;
      c.vld   = s_tvalid && lane_used[i];
      c.sop   = s_tvalid && (i == 0) && !in_frame;
      c.eop   = s_tvalid && s_tlast && (IDX_W'(i) == lidx);
      c.err   = c.eop && s_tuser;
      c.empty = c.eop ? emp : '0;
      ctrl_n[i*CTRL_W +: CTRL_W] = c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_data <= '0;
      lane_ctrl <= '0;
      in_frame  <= 1'b0;
    end else if (mac_ready) begin
      lane_data <= s_tdata;
      lane_ctrl <= ctrl_n;
      if (take) in_frame <= !s_tlast;
    end
  end
endmodule

// File: rtl/lane_stream_adapter.sv
module lane_stream_adapter
  import lsa_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES*LANE_W-1:0]       rx_lane_data,
  input  logic [LANES*CTRL_W-1:0]       rx_lane_ctrl,
  output logic                          m_tvalid,
  output logic [LANES*LANE_W-1:0]       m_tdata,
  output logic [LANES*LANE_B-1:0]       m_tkeep,
  output logic                          m_tlast,
  output logic                          m_tuser,
  output logic [LANES*LANE_W-1:0]       tx_lane_data,
  output logic [LANES*CTRL_W-1:0]       tx_lane_ctrl,
  input  logic                          tx_mac_ready,
  input  logic                          s_tvalid,
  output logic                          s_tready,
  input  logic [LANES*LANE_W-1:0]       s_tdata,
  input  logic [LANES*LANE_B-1:0]       s_tkeep,
  input  logic                          s_tlast,
  input  logic                          s_tuser
);
  lsa_rx_pack #(.LANES(LANES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_data (rx_lane_data),
    .lane_ctrl (rx_lane_ctrl),
    .tvalid    (m_tvalid),
    .tdata     (m_tdata),
    .tkeep     (m_tkeep),
    .tlast     (m_tlast),
    .tuser     (m_tuser)
  );

  lsa_tx_unpack #(.LANES(LANES)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .s_tdata   (s_tdata),
    .s_tkeep   (s_tkeep),
    .s_tlast   (s_tlast),
    .s_tuser   (s_tuser),
    .mac_ready (tx_mac_ready),
    .lane_data (tx_lane_data),
    .lane_ctrl (tx_lane_ctrl)
  );
endmodule

// File: rtl/lane_stream_adapter_chk.sv
module lane_stream_adapter_chk
  import lsa_pkg::*;
#(
  parameter int LANES = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LANES*CTRL_W-1:0]  rx_lane_ctrl,
  input logic                     m_tvalid,
  input logic [LANES*LANE_B-1:0]  m_tkeep,
  input logic                     m_tlast,
  input logic                     m_tuser,
  input logic [LANES*LANE_W-1:0]  tx_lane_data,
  input logic [LANES*CTRL_W-1:0]  tx_lane_ctrl,
  input logic                     tx_mac_ready
);
  logic [LANES-1:0] eop_v, err_v, sop_v, vld_v;

  for (genvar g = 0; g < LANES; g++) begin : g_flags
    assign eop_v[g] = tx_lane_ctrl[g*CTRL_W + B_EOP];
    assign err_v[g] = tx_lane_ctrl[g*CTRL_W + B_ERR];
    assign sop_v[g] = tx_lane_ctrl[g*CTRL_W + B_SOP];
    assign vld_v[g] = tx_lane_ctrl[g*CTRL_W + B_VLD];
  end

  // R2
  rx_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lane_ctrl[B_VLD] |=> m_tvalid);

  // R2
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lane_ctrl[B_VLD] |=> !m_tvalid);

  // R4
  rx_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> !m_tuser);

  // R3
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tkeep[0]);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mac_ready |=> ($stable(tx_lane_data) && $stable(tx_lane_ctrl)));

  // R9
  tx_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eop_v));

  // R9
  tx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_v & ~eop_v) == '0);

  // R8
  tx_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_v & ~vld_v) == '0);
endmodule

bind lane_stream_adapter lane_stream_adapter_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_lane_ctrl (rx_lane_ctrl),
  .m_tvalid     (m_tvalid),
  .m_tkeep      (m_tkeep),
  .m_tlast      (m_tlast),
  .m_tuser      (m_tuser),
  .tx_lane_data (tx_lane_data),
  .tx_lane_ctrl (tx_lane_ctrl),
  .tx_mac_ready (tx_mac_ready)
);

// File: tb/lane_stream_adapter_bench.sv
`timescale 1ns/1ps
module lane_stream_adapter_bench;
  localparam int L  = 6;
  localparam int DW = 384;
  localparam int KW = 48;
  localparam int CW = 42;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] rx_lane_data;
  logic [CW-1:0] rx_lane_ctrl;
  logic          m_tvalid, m_tlast, m_tuser;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;
  logic [DW-1:0] tx_lane_data;
  logic [CW-1:0] tx_lane_ctrl;
  logic          tx_mac_ready;
  logic          s_tvalid, s_tready, s_tlast, s_tuser;
  logic [DW-1:0] s_tdata;
  logic [KW-1:0] s_tkeep;

  lane_stream_adapter u_lane_stream_adapter (
    .clk(clk), .rst_n(rst_n),
    .rx_lane_data(rx_lane_data), .rx_lane_ctrl(rx_lane_ctrl),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .m_tuser(m_tuser),
    .tx_lane_data(tx_lane_data), .tx_lane_ctrl(tx_lane_ctrl),
    .tx_mac_ready(tx_mac_ready),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tuser(s_tuser)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rand_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  // R3: n leading bytes kept
  function automatic logic [KW-1:0] keep_of(int n);
    if (n >= KW) return '1;
    return (48'd1 << n) - 48'd1;
  endfunction

  // R1/R7/R8/R9: expected transmit control words
  function automatic logic [CW-1:0] tx_ctrl_exp(logic [KW-1:0] k, bit last, bit usr, bit first);
    logic [CW-1:0] c = '0;
    int hi = 0;
    int cnt = 0;
    for (int i = 0; i < L; i++) if (k[i*8 +: 8] != 0) hi = i;
    for (int j = 0; j < 8; j++) cnt += k[hi*8 + j];
    for (int i = 0; i < L; i++) begin
      c[i*7 + 0] = (k[i*8 +: 8] != 0);
      c[i*7 + 1] = (i == 0) && first;
      if (last && i == hi) begin
        c[i*7 + 2] = 1'b1;
        c[i*7 + 3] = usr;
        c[i*7 + 4 +: 3] = 3'((8 - cnt) % 8);
      end
    end
    return c;
  endfunction

  function automatic int pick_len(int idx);
    int dir [8] = '{1, 8, 9, 48, 49, 96, 41, 100};
    if (idx < 8) return dir[idx];
    return 1 + int'($urandom % 200);
  endfunction

  initial begin
    #(5.0 * (NCYC + 2000));
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // receive model state
    int rx_rem = 0, rx_fidx = 0;
    bit rx_first = 0, rx_err = 0;
    bit ex_v = 0, ex_last = 0, ex_user = 0;
    logic [DW-1:0] ex_data = '0;
    logic [KW-1:0] ex_keep = '0;
    // transmit model state
    int tx_rem = 0, tx_fidx = 0, tx_n = 0;
    bit tx_has = 0, tx_first = 1;
    bit p_ready = 0, p_valid = 0, p_last = 0, p_user = 0;
    logic [DW-1:0] p_data = '0;
    logic [KW-1:0] p_keep = '0;
    logic [CW-1:0] ex_ctrl = '0;
    logic [DW-1:0] ex_tdata = '0;
    logic [DW-1:0] seen_data;

    void'($urandom(32'd7741));
    rst_n = 1'b0;
    rx_lane_data = '0; rx_lane_ctrl = '0;
    tx_mac_ready = 1'b0; s_tvalid = 1'b0; s_tdata = '0;
    s_tkeep = '0; s_tlast = 1'b0; s_tuser = 1'b0;
    repeat (3) @(negedge clk);
    // R5
    check(m_tvalid == 1'b0, "R5 rx valid in reset", DW'(m_tvalid), '0);
    check(tx_lane_ctrl == '0, "R5 tx ctrl in reset", DW'(tx_lane_ctrl), '0);
    seen_data = tx_lane_data;
    rst_n = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // ---- receive checks (R2/R3/R4)
      if (ex_v) begin
        check(m_tvalid == 1'b1, "R2 rx valid", DW'(m_tvalid), DW'(1));
        check(m_tdata == ex_data, "R1 R2 rx data", m_tdata, ex_data);
        check(m_tkeep == ex_keep, "R3 rx keep", DW'(m_tkeep), DW'(ex_keep));
        check(m_tlast == ex_last, "R4 rx last", DW'(m_tlast), DW'(ex_last));
        check(m_tuser == ex_user, "R4 rx user", DW'(m_tuser), DW'(ex_user));
      end else begin
        check(m_tvalid == 1'b0, "R2 rx idle", DW'(m_tvalid), '0);
      end
      // ---- transmit checks (R7/R8/R9/R10)
      if (p_ready) begin
        ex_ctrl = p_valid ? tx_ctrl_exp(p_keep, p_last, p_user, tx_first) : '0;
        ex_tdata = p_data;
        if (p_valid) begin
          tx_first = p_last;
          tx_rem -= tx_n;
          tx_has = 0;
        end
        check(tx_lane_ctrl == ex_ctrl, "R7 R8 R9 tx ctrl", DW'(tx_lane_ctrl), DW'(ex_ctrl));
        if (p_valid)
          check(tx_lane_data == ex_tdata, "R7 tx data", tx_lane_data, ex_tdata);
      end else begin
        check(tx_lane_ctrl == ex_ctrl, "R10 tx ctrl hold", DW'(tx_lane_ctrl), DW'(ex_ctrl));
        check(tx_lane_data == seen_data, "R10 tx data hold", tx_lane_data, seen_data);
      end
      seen_data = tx_lane_data;

      // ---- drive receive
      rx_lane_data = rand_data();
      rx_lane_ctrl = '0;
      ex_v = 0;
      if (($urandom % 5) != 0) begin
        int n;
        bit last;
        if (rx_rem == 0) begin
          rx_rem = pick_len(rx_fidx);
          rx_fidx++;
          rx_first = 1;
          rx_err = (($urandom % 3) == 0);
        end
        n = (rx_rem > 48) ? 48 : rx_rem;
        last = (rx_rem <= 48);
        for (int i = 0; i < L; i++) begin
          if (i * 8 < n) begin
            rx_lane_ctrl[i*7 + 0] = 1'b1;
            rx_lane_ctrl[i*7 + 1] = (i == 0) && rx_first;
            if (last && i == (n - 1) / 8) begin
              rx_lane_ctrl[i*7 + 2] = 1'b1;
              rx_lane_ctrl[i*7 + 3] = rx_err;
              rx_lane_ctrl[i*7 + 4 +: 3] = 3'((8 - (n - 8 * i)) % 8);
            end
          end
        end
        ex_v = 1; ex_data = rx_lane_data; ex_keep = keep_of(n);
        ex_last = last; ex_user = last && rx_err;
        rx_rem -= n;
        rx_first = 0;
      end

      // ---- drive transmit
      if (!tx_has) begin
        if (tx_rem == 0) begin
          tx_rem = pick_len(tx_fidx);
          tx_fidx++;
        end
        tx_n = (tx_rem > 48) ? 48 : tx_rem;
        s_tdata = rand_data();
        s_tkeep = keep_of(tx_n);
        s_tlast = (tx_rem <= 48);
        s_tuser = s_tlast && (($urandom % 3) == 0);
        tx_has = 1;
        s_tvalid = (($urandom % 4) != 0);
      end else if (!s_tvalid) begin
        s_tvalid = (($urandom % 4) != 0);
      end
      tx_mac_ready = (cyc < 40) ? 1'b1 : (($urandom % 10) < 7);
      p_ready = tx_mac_ready; p_valid = s_tvalid;
      p_data = s_tdata; p_keep = s_tkeep; p_last = s_tlast; p_user = s_tuser;
      #1;
      // R6
      check(s_tready == tx_mac_ready, "R6 tready", DW'(s_tready), DW'(tx_mac_ready));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule